// File: doc/BRIEF.md
# Single-Channel Transfer Engine with Width Conversion

This block moves a programmed number of data items from a source address to a destination address on behalf of one transfer channel. For each item it reads once from the source and writes once to the destination over a plain request/acknowledge memory port. The source and destination item widths are chosen separately. The item read is narrowed or zero-extended to the destination width before it is written. Each address can step by its own item size after every item, or stay fixed, as a peripheral data register would. This one engine therefore serves memory-to-memory, memory-to-peripheral, peripheral-to-memory and peripheral-to-peripheral moves.

An external arbiter grants the channel one item at a time. Software enables the channel with a level signal. The engine raises three sticky event flags: midpoint reached, block finished, and fault. Each flag can be cleared by software and enabled onto a shared interrupt line. In wrap-around mode the block restarts by itself from its programmed addresses and count. A fault stops the channel until software takes the enable low and then high again.

Top module: `dma_xfer_engine`

## Requirements
- R1: Size codes are 0 = byte, 1 = half word, 2 = word. Each item is one read at the source address with the source size, followed by one write at the destination address with the destination size. A request stays asserted, with address and direction unchanged, until it is acknowledged.
- R2: After each completed item, the source address advances by the source item size (1, 2 or 4 bytes) when its increment bit is set. The destination address advances by the destination item size when its increment bit is set. An address whose increment bit is clear stays the same.
- R3: Data is right-justified on the 32-bit buses. The item read keeps only the low bits of the source size. The write data is that item cut to the destination size, so a wider destination receives zero-extended data and a narrower one receives the low-order bits.
- R4: When a transfer starts, the remaining count loads the programmed count. A programmed count of 0 means 65536. The count drops by one at each completed write.
- R5: The midpoint flag sets when a completed write leaves the remaining count equal to half the total, rounded down. With a total of one, the midpoint flag and the finish flag set in the same cycle.
- R6: The finish flag sets when a completed write leaves zero items. Outside wrap-around mode, no further access is made until the enable has gone low and then high again.
- R7: In wrap-around mode the finish flag still sets. The count and both addresses then reload from the programmed values, and the transfer continues without software action.
- R8: If either address at start is not aligned to its own item size, or either size code is 3, the fault flag sets and no access is made.
- R9: An error response to a read or a write sets the fault flag and stops the channel without counting that item. The channel stays stopped while the enable is held high.
- R10: A new item starts only while grant is high. An item already started completes even if grant falls.
- R11: When the enable falls during a transfer, the current item completes and the engine then goes idle with no request and busy low.
- R12: A pulse on a flag's clear input clears that flag. If the flag's event happens in the same cycle, the flag stays set.
- R13: The interrupt output is high exactly when at least one flag is set together with its mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable level |
| grant | input | 1 | Permission from the arbiter to start an item |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_cnt | input | CW | Item count, 0 meaning 2^CW |
| cfg_ssz | input | 2 | Source item size code |
| cfg_dsz | input | 2 | Destination item size code |
| cfg_sinc | input | 1 | Source address increment enable |
| cfg_dinc | input | 1 | Destination address increment enable |
| cfg_circ | input | 1 | Wrap-around mode |
| msk_ht | input | 1 | Interrupt mask for the midpoint flag |
| msk_tc | input | 1 | Interrupt mask for the finish flag |
| msk_te | input | 1 | Interrupt mask for the fault flag |
| clr_ht | input | 1 | Clear pulse for the midpoint flag |
| clr_tc | input | 1 | Clear pulse for the finish flag |
| clr_te | input | 1 | Clear pulse for the fault flag |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, right-justified |
| mem_ack | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Completing access returned an error |
| flg_ht | output | 1 | Midpoint flag |
| flg_tc | output | 1 | Finish flag |
| flg_te | output | 1 | Fault flag |
| irq | output | 1 | Combined masked interrupt |
| busy | output | 1 | Transfer in progress |
| remaining | output | CW+1 | Items left in the current pass |

## Verification
Two events can land on the same clock edge. The first case is the finishing write of a one-item block, which sets the midpoint and finish flags together. The second is a software clear arriving in the very cycle its flag's event fires. The bench provokes both with one-item transfers, once while clear inputs are held high, and once in wrap-around mode so that the coincidence repeats on every lap. A reference model updates each flag every cycle as "clear, then set" and compares the flags, the interrupt and the remaining count on every clock. A lost set or a surviving clear is therefore reported in the exact cycle it happens.

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          grant,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_cnt,
  input  logic [1:0]    cfg_ssz,
  input  logic [1:0]    cfg_dsz,
  input  logic          cfg_sinc,
  input  logic          cfg_dinc,
  input  logic          cfg_circ,
  input  logic          msk_ht,
  input  logic          msk_tc,
  input  logic          msk_te,
  input  logic          clr_ht,
  input  logic          clr_tc,
  input  logic          clr_te,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          flg_ht,
  output logic          flg_tc,
  output logic          flg_te,
  output logic          irq,
  output logic          busy,
  output logic [CW:0]   remaining
);
  localparam int RW = CW + 1;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_RD, S_WR, S_STOP} st_t;

  function automatic logic [AW-1:0] step_of(input logic [1:0] sz);
    case (sz)
      2'd0:    step_of = AW'(1);
      2'd1:    step_of = AW'(2);
      default: step_of = AW'(4);
    endcase
  endfunction

  function automatic logic [31:0] mask_of(input logic [1:0] sz);
    case (sz)
      2'd0:    mask_of = 32'h0000_00FF;
      2'd1:    mask_of = 32'h0000_FFFF;
      default: mask_of = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic misfit(input logic [AW-1:0] a, input logic [1:0] sz);
    misfit = (sz == 2'd3) || ((a & (step_of(sz) - AW'(1))) != '0);
  endfunction

  st_t           st;
  logic [AW-1:0] sa, da;
  logic [RW-1:0] rem;
  logic [31:0]   dbuf;

  logic [RW-1:0] total, half, rem_nx;
  logic          cfg_bad, acc_done, wr_ok, ev_ht, ev_tc, ev_te;

  assign total    = (cfg_cnt == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, cfg_cnt};
  assign half     = total >> 1;
  assign rem_nx   = rem - RW'(1);
  assign cfg_bad  = misfit(cfg_src, cfg_ssz) | misfit(cfg_dst, cfg_dsz);
  assign acc_done = mem_req & mem_ack;
  assign wr_ok    = acc_done & ~mem_err & (st == S_WR);
  assign ev_ht    = wr_ok & (rem_nx == half);
  assign ev_tc    = wr_ok & (rem_nx == '0);
  assign ev_te    = (acc_done & mem_err) | ((st == S_IDLE) & en & cfg_bad);

  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = mem_we ? da : sa;
  assign mem_size  = mem_we ? cfg_dsz : cfg_ssz;
  assign mem_wdata = dbuf & mask_of(cfg_dsz);
  assign busy      = (st == S_WAIT) || mem_req;
  assign remaining = rem;
  assign irq       = (flg_ht & msk_ht) | (flg_tc & msk_tc) | (flg_te & msk_te);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      sa   <= '0;
      da   <= '0;
      rem  <= '0;
      dbuf <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (en) begin
            if (cfg_bad) st <= S_STOP;
            else begin
              sa  <= cfg_src;
              da  <= cfg_dst;
              rem <= total;
              st  <= S_WAIT;
            end
          end
        S_WAIT:
          if (!en)        st <= S_IDLE;
          else if (grant) st <= S_RD;
        S_RD:
          if (mem_ack) begin
            if (mem_err) st <= S_STOP;
            else begin
              dbuf <= mem_rdata & mask_of(cfg_ssz);
              st   <= S_WR;
            end
          end
        S_WR:
          if (mem_ack) begin
            if (mem_err) st <= S_STOP;
            else if (rem_nx == '0 && cfg_circ) begin
              sa  <= cfg_src;
              da  <= cfg_dst;
              rem <= total;
              st  <= S_WAIT;
            end else begin
              sa  <= sa + (cfg_sinc ? step_of(cfg_ssz) : '0);
              da  <= da + (cfg_dinc ? step_of(cfg_dsz) : '0);
              rem <= rem_nx;
              st  <= (rem_nx == '0) ? S_STOP : S_WAIT;
            end
          end
        S_STOP:
          if (!en) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_ht <= 1'b0;
      flg_tc <= 1'b0;
      flg_te <= 1'b0;
    end else begin
      flg_ht <= (flg_ht & ~clr_ht) | ev_ht;
      flg_tc <= (flg_tc & ~clr_tc) | ev_tc;
      flg_te <= (flg_te & ~clr_te) | ev_te;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R1
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack && !mem_err |=> mem_req && mem_we); // R1
  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr & (step_of(mem_size) - AW'(1))) == '0); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack && !mem_err && remaining > RW'(1)
    |=> remaining == $past(remaining) - RW'(1)); // R4
  AST_TC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack && !mem_err && remaining == RW'(1) |=> flg_tc); // R6
  AST_ERR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_te) |-> !mem_req && !busy); // R9
  AST_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WAIT && !grant |=> !mem_req); // R10
  AST_HT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ht && !(mem_req && mem_we && mem_ack) |=> !flg_ht); // R12
endmodule

// File: tb/tb_dma_xfer_engine.sv
`timescale 1ns/1ps
module tb_dma_xfer_engine;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic en = 0, grant = 0;
  logic [AW-1:0] cfg_src = 0, cfg_dst = 0;
  logic [CW-1:0] cfg_cnt = 0;
  logic [1:0] cfg_ssz = 0, cfg_dsz = 0;
  logic cfg_sinc = 0, cfg_dinc = 0, cfg_circ = 0;
  logic msk_ht = 1, msk_tc = 1, msk_te = 1;
  logic clr_ht = 0, clr_tc = 0, clr_te = 0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_size;
  logic [31:0] mem_wdata, mem_rdata;
  logic mem_ack = 0, mem_err = 0;
  logic flg_ht, flg_tc, flg_te, irq, busy;
  logic [CW:0] remaining;

  assign mem_rdata = (mem_addr * 32'h9E37_79B1) ^ 32'h5A5A_1234;

  dma_xfer_engine #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .grant(grant),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
    .cfg_ssz(cfg_ssz), .cfg_dsz(cfg_dsz), .cfg_sinc(cfg_sinc),
    .cfg_dinc(cfg_dinc), .cfg_circ(cfg_circ),
    .msk_ht(msk_ht), .msk_tc(msk_tc), .msk_te(msk_te),
    .clr_ht(clr_ht), .clr_tc(clr_tc), .clr_te(clr_te),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .mem_err(mem_err),
    .flg_ht(flg_ht), .flg_tc(flg_tc), .flg_te(flg_te), .irq(irq),
    .busy(busy), .remaining(remaining)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
    end
  endtask

  function automatic int step_of(input logic [1:0] sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction
  function automatic logic [31:0] mask_of(input logic [1:0] sz);
    return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction
  function automatic bit cfg_bad();
    if (cfg_ssz == 3 || cfg_dsz == 3) return 1;
    return (cfg_src % step_of(cfg_ssz) != 0) || (cfg_dst % step_of(cfg_dsz) != 0);
  endfunction
  function automatic int total_of();
    return (cfg_cnt == 0) ? 65536 : int'(cfg_cnt);
  endfunction

  // reference model state
  bit m_act = 0, m_wrn = 0, m_ht = 0, m_tc = 0, m_te = 0;
  logic [31:0] m_sa = 0, m_da = 0, m_data = 0;
  int m_rem = 0, tc_seen = 0;
  bit e_ht, e_tc, e_te;
  // stimulus requests, written on rising edges, applied on falling edges
  bit w_en = 0, w_grant = 1;
  logic [2:0] w_clr = 0, clr_hold = 0;
  int err_at = -1, hs = 0, lat = 0, lat_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 remaining", remaining, m_rem);
      chk("R5 midpoint flag", flg_ht, m_ht);
      chk("R6 finish flag", flg_tc, m_tc);
      chk("R8/R9 fault flag", flg_te, m_te);
      chk("R13 irq", irq, (m_ht & msk_ht) | (m_tc & msk_tc) | (m_te & msk_te));
      e_ht = 0; e_tc = 0; e_te = 0;
      clr_ht = w_clr[0] | clr_hold[0];
      clr_tc = w_clr[1] | clr_hold[1];
      clr_te = w_clr[2] | clr_hold[2];
      w_clr = 0;
      grant = w_grant;
      mem_ack = 0; mem_err = 0;
      if (w_en && !en) begin
        en = 1; hs = 0;
        if (cfg_bad()) e_te = 1;
        else begin
          m_act = 1; m_wrn = 0; m_rem = total_of(); m_sa = cfg_src; m_da = cfg_dst;
        end
      end else if (!w_en && en) en = 0;
      if (mem_req) begin
        if (lat_cnt >= lat) begin
          mem_ack = 1; mem_err = (hs == err_at); hs++;
          lat_cnt = 0; lat = $urandom_range(0, 2);
          chk("R6/R9 no access while stopped", m_act, 1);
          if (!m_wrn) begin
            chk("R1 read direction", mem_we, 0);
            chk("R2 source address", mem_addr, m_sa);
            chk("R1 source size", mem_size, cfg_ssz);
            if (mem_err) begin e_te = 1; m_act = 0; end
            else begin m_data = mem_rdata & mask_of(cfg_ssz); m_wrn = 1; end
          end else begin
            chk("R1 write direction", mem_we, 1);
            chk("R2 destination address", mem_addr, m_da);
            chk("R1 destination size", mem_size, cfg_dsz);
            chk("R3 write data", mem_wdata, m_data & mask_of(cfg_dsz));
            m_wrn = 0;
            if (mem_err) begin e_te = 1; m_act = 0; end
            else begin
              m_sa += cfg_sinc ? step_of(cfg_ssz) : 0;
              m_da += cfg_dinc ? step_of(cfg_dsz) : 0;
              m_rem--;
              if (m_rem == total_of() / 2) e_ht = 1;
              if (m_rem == 0) begin
                e_tc = 1; tc_seen++;
                if (cfg_circ) begin m_rem = total_of(); m_sa = cfg_src; m_da = cfg_dst; end
                else m_act = 0;
              end
            end
          end
        end else lat_cnt++;
      end
      m_ht = (m_ht & !clr_ht) | e_ht;
      m_tc = (m_tc & !clr_tc) | e_tc;
      m_te = (m_te & !clr_te) | e_te;
    end
  end

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input int cnt,
                       input logic [1:0] ss, input logic [1:0] ds,
                       input bit si, input bit di, input bit ci);
    @(posedge clk);
    cfg_src = s; cfg_dst = d; cfg_cnt = CW'(cnt); cfg_ssz = ss; cfg_dsz = ds;
    cfg_sinc = si; cfg_dinc = di; cfg_circ = ci;
  endtask

  task automatic finish_run();
    int t = 0;
    while (m_act && t < 5000) begin @(posedge clk); t++; end
    @(posedge clk) w_en = 0;
    repeat (4) @(posedge clk);
  endtask

  task automatic run();
    @(posedge clk) w_en = 1;
    repeat (3) @(posedge clk);
    finish_run();
  endtask

  task automatic quiet(input string what, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(what, mem_req, 0);
    end
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int base, r;
    repeat (3) @(negedge clk);
    chk("R4 reset remaining", remaining, 0);
    chk("R1 reset request", mem_req, 0);
    chk("R12 reset flags", {flg_ht, flg_tc, flg_te}, 0);
    chk("R13 reset irq", irq, 0);
    rst_n = 1;
    repeat (2) @(posedge clk);

    // word to word, both incrementing
    setup(32'h1000, 32'h2000, 6, 2, 2, 1, 1, 0); run();
    @(posedge clk) w_clr = 3'b111;
    @(negedge clk); @(negedge clk);
    chk("R12 clear all flags", {flg_ht, flg_tc, flg_te}, 0);
    // byte source to word peripheral: zero-extend, fixed destination
    setup(32'h3001, 32'h4000, 5, 0, 2, 1, 0, 0); run();
    // word source fixed to halfword memory: truncate
    setup(32'h5000, 32'h6002, 4, 2, 1, 0, 1, 0); run();
    // single item with clears held: midpoint and finish together, clear loses
    clr_hold = 3'b011;
    setup(32'h7002, 32'h7101, 1, 1, 0, 1, 1, 0); run();
    clr_hold = 3'b000;
    // masks off: flags set but irq stays low
    msk_ht = 0; msk_tc = 0;
    setup(32'h8000, 32'h8800, 3, 1, 1, 1, 1, 0); run();
    chk("R13 masked finish keeps irq low", irq, 0);
    msk_ht = 1; msk_tc = 1;
    @(posedge clk) w_clr = 3'b111;
    // wrap-around, repeated single-item coincidence
    base = tc_seen;
    setup(32'h9000, 32'hA000, 1, 2, 2, 1, 1, 1);
    @(posedge clk) w_en = 1;
    begin int t = 0; while (tc_seen - base < 3 && t < 500) begin @(posedge clk); t++; end end
    base = tc_seen;
    setup(32'h9000, 32'hA000, 3, 2, 0, 1, 1, 1);
    begin int t = 0; while (tc_seen - base < 2 && t < 500) begin @(posedge clk); t++; end end
    @(posedge clk) w_en = 0;
    repeat (12) @(posedge clk);
    chk("R7 wrap laps", (tc_seen - base) >= 2, 1);
    quiet("R7 idle after disable", 3);
    // misaligned start and reserved size
    @(posedge clk) w_clr = 3'b111;
    setup(32'hB002, 32'hC000, 4, 2, 2, 1, 1, 0);
    @(posedge clk) w_en = 1;
    quiet("R8 no access on misaligned start", 8);
    chk("R8 fault flag on misalignment", flg_te, 1);
    chk("R8 busy low", busy, 0);
    @(posedge clk) w_en = 0; w_clr = 3'b100;
    repeat (4) @(posedge clk);
    setup(32'hB000, 32'hC000, 4, 3, 2, 1, 1, 0);
    @(posedge clk) w_en = 1;
    quiet("R8 no access on reserved size", 6);
    chk("R8 fault flag on size 3", flg_te, 1);
    @(posedge clk) w_en = 0; w_clr = 3'b100;
    repeat (4) @(posedge clk);
    // bus error on first read, then on second write
    err_at = 0;
    setup(32'hD000, 32'hE000, 4, 2, 2, 1, 1, 0);
    @(posedge clk) w_en = 1;
    repeat (12) @(posedge clk);
    quiet("R9 halted after read error", 8);
    chk("R9 count unchanged after read error", remaining, 4);
    @(posedge clk) w_en = 0; w_clr = 3'b100;
    repeat (4) @(posedge clk);
    err_at = 3;
    @(posedge clk) w_en = 1;
    repeat (25) @(posedge clk);
    quiet("R9 halted after write error", 8);
    chk("R9 count after write error", remaining, 3);
    @(posedge clk) w_en = 0; w_clr = 3'b100; err_at = -1;
    repeat (4) @(posedge clk);
    run();
    // grant withdrawn mid-block
    setup(32'h1_0000, 32'h1_1000, 12, 1, 2, 1, 1, 0);
    @(posedge clk) w_en = 1;
    repeat (14) @(posedge clk);
    w_grant = 0;
    repeat (10) @(posedge clk);
    @(negedge clk) r = remaining;
    quiet("R10 no request without grant", 10);
    chk("R10 count frozen without grant", remaining, r);
    @(posedge clk) w_grant = 1;
    finish_run();
    // enable dropped mid-block
    setup(32'h2_0000, 32'h2_1000, 20, 0, 0, 1, 1, 0);
    @(posedge clk) w_en = 1;
    repeat (15) @(posedge clk);
    w_en = 0;
    repeat (10) @(posedge clk);
    quiet("R11 idle after disable", 6);
    chk("R11 busy low after disable", busy, 0);
    repeat (2) @(posedge clk);
    // count zero means full range
    setup(32'h3_0000, 32'h3_0000, 0, 2, 2, 1, 0, 0);
    @(posedge clk) w_en = 1;
    @(posedge clk);
    @(negedge clk) chk("R4 count zero loads 65536", remaining, 65536);
    repeat (30) @(posedge clk);
    w_en = 0;
    repeat (12) @(posedge clk);
    quiet("R11 idle after full-range abort", 3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule